// File: doc/BRIEF.md
# Indexed RTC Register Port

This block is the software-facing register window of a real-time clock and battery-backed configuration store. It exposes a 128-byte register file through two byte addresses. A write to the even address selects a byte, and an access to the odd address reads or writes the selected byte. Most bytes are plain storage. The four control and status bytes follow their own rules:

- Bit 7 of the first control byte is an update-in-progress flag that software cannot write.
- The status byte clears itself when it is read.
- The two status bytes cannot be written.
- Bit 7 of the second control byte places the clock in set mode.

The time-keeping logic outside the block signals events and update progress through pulse inputs. The block gates each event with its enable bit, records it in the status byte and raises a registered interrupt request. The interrupt request stays high until software reads the status byte. The block also keeps a 16-bit additive checksum over the configuration range 0x10 to 0x2D. It stores the checksum in the two bytes that follow the range, in the same cycle as the write that changed the range.

Top module: `cmosRegPort`

## Requirements
- R1: A write with addrSel=0 loads wrData[6:0] as the index, and bit 7 of the data is discarded. A read with addrSel=0 returns 0xFF.
- R2: With addrSel=1, a write stores wrData into the indexed byte, and a read returns the indexed byte combinationally. This applies to every index except 10 to 13.
- R3: A write to index 10 (control A) updates bits 6:0 and leaves bit 7 (update in progress) unchanged.
- R4: Writes to index 12 (status C) and index 13 (status D) change nothing.
- R5: A read of index 12 returns its current value. From the next cycle the byte reads 0x00 and irq is low.
- R6: A write to index 11 (control B) with data bit 7 set clears bit 7 of index 10. The setMode output equals bit 7 of index 11.
- R7: After reset, index 10 reads 0x26, index 11 reads 0x02, index 12 reads 0x00 and index 13 reads 0x80. irq and setMode are low.
- R8: After any write to an index in 0x10..0x2D, the 16-bit sum of bytes 0x10..0x2D is held with its high byte at 0x2E and its low byte at 0x2F. The new value is readable in the next cycle.
- R9: The three event pulses are gated by enable bits in index 11: evtPeriodic by bit 6, evtAlarm by bit 5, evtUpdate by bit 4.
  - An enabled pulse sets the matching bit of index 12 (bit 6, bit 5 or bit 4) and also sets bit 7 of index 12.
  - An enabled pulse drives irq high from the next cycle.
  - A pulse whose enable bit is 0 leaves index 12 and irq unchanged.
- R10: An enabled event in the same cycle as a clearing read of index 12 takes priority over the clear. Afterwards the byte holds only the new flags plus bit 7, and irq stays high.
- R11: A uipSet pulse sets bit 7 of index 10 only while bit 7 of index 11 is 0. A uipClr pulse clears bit 7 of index 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrSel | input | 1 | Address LSB: 0 selects the index, 1 selects the data byte |
| wrData | input | 8 | Write data |
| wrStrobe | input | 1 | Write strobe, one cycle per access |
| rdStrobe | input | 1 | Read strobe, one cycle per access |
| evtPeriodic | input | 1 | Periodic event pulse from the timing logic |
| evtAlarm | input | 1 | Alarm match pulse from the timing logic |
| evtUpdate | input | 1 | Update-ended pulse from the timing logic |
| uipSet | input | 1 | Update-started pulse from the timing logic |
| uipClr | input | 1 | Update-finished pulse from the timing logic |
| rdData | output | 8 | Read data, valid while rdStrobe is high |
| irq | output | 1 | Registered interrupt request |
| setMode | output | 1 | Set-mode bit of control B |

## Verification
The hardest case to reach is an event that lands in the same cycle as the clearing read of the status byte. In that cycle the read must still return the old flags, while the byte keeps the new flag and the interrupt request stays high. The bench reaches it by setting the read strobe and the alarm pulse together on the same falling edge, after an update-ended event has already filled the byte. The update-in-progress bit is driven high through uipSet, so a write can be shown to leave a set bit alone. uipSet is then issued again while set mode is active to show that it is refused.

// File: rtl/cmosRegPkg.sv
package cmosRegPkg;
  localparam int IDX_W  = 7;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int DATA_W = 8;
  localparam int CSUM_W = 2 * DATA_W;
  localparam int EVT_N  = 3;

  localparam int REG_A = 10;
  localparam int REG_B = 11;
  localparam int REG_C = 12;
  localparam int REG_D = 13;
  localparam int CSUM_FIRST = 16;
  localparam int CSUM_LAST  = 45;
  localparam int CSUM_HI    = 46;
  localparam int CSUM_LO    = 47;

  localparam logic [IDX_W-1:0] IDX_A = IDX_W'(REG_A);
  localparam logic [IDX_W-1:0] IDX_B = IDX_W'(REG_B);
  localparam logic [IDX_W-1:0] IDX_C = IDX_W'(REG_C);
  localparam logic [IDX_W-1:0] IDX_D = IDX_W'(REG_D);

  // bit positions decoded by the timing logic and by software
  localparam int UIP_BIT = 7;   // in control A
  localparam int SET_BIT = 7;   // in control B
  localparam int EN_LSB  = 4;   // control B bits 6:4 enable periodic, alarm, update
  localparam int ANY_BIT = 7;   // in status C, summary of any flag

  localparam logic [DATA_W-1:0] RST_A = 8'h26;
  localparam logic [DATA_W-1:0] RST_B = 8'h02;
  localparam logic [DATA_W-1:0] RST_C = 8'h00;
  localparam logic [DATA_W-1:0] RST_D = 8'h80;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic              wrPlain;
    logic              wrRegA;
    logic              wrRegB;
    logic              rdClrC;
    logic [DATA_W-1:0] cSet;
    logic              uipSet;
    logic              uipClr;
  } ctlStrobes_t;
endpackage

// File: rtl/cmosCtrl.sv
module cmosCtrl
  import cmosRegPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrSel,
  input  logic             wrStrobe,
  input  logic             rdStrobe,
  input  logic [IDX_W-1:0] idxIn,
  input  logic             evtPeriodic,
  input  logic             evtAlarm,
  input  logic             evtUpdate,
  input  logic             uipSet,
  input  logic             uipClr,
  input  logic [EVT_N-1:0] evtEn,
  input  logic             setModeIn,
  output ctlStrobes_t      strb,
  output logic             irq
);
  logic [IDX_W-1:0] idxQ;
  logic             dataWr;
  logic             statusHit;
  logic [EVT_N-1:0] evtHit;

  always_ff @(posedge clk) begin
    if (!rstN)                     idxQ <= '0;
    else if (wrStrobe && !addrSel) idxQ <= idxIn;
  end

  assign dataWr    = wrStrobe && addrSel;
  assign statusHit = (idxQ == IDX_C) || (idxQ == IDX_D);
  assign evtHit    = {evtPeriodic, evtAlarm, evtUpdate} & evtEn;

  always_comb begin
    strb         = '0;
    strb.idx     = idxQ;
    strb.wrRegA  = dataWr && (idxQ == IDX_A);
    strb.wrRegB  = dataWr && (idxQ == IDX_B);
    strb.wrPlain = dataWr && !statusHit && (idxQ != IDX_A) && (idxQ != IDX_B);
    strb.rdClrC  = rdStrobe && addrSel && (idxQ == IDX_C);
    strb.cSet[EN_LSB +: EVT_N] = evtHit;
    strb.cSet[ANY_BIT]         = |evtHit;
    strb.uipSet  = uipSet && !setModeIn;
    strb.uipClr  = uipClr;
  end

  // interrupt request: any enabled event raises it, a status read drops it
  always_ff @(posedge clk) begin
    if (!rstN)            irq <= 1'b0;
    else if (|evtHit)     irq <= 1'b1;
    else if (strb.rdClrC) irq <= 1'b0;
  end
endmodule

// File: rtl/cmosDatapath.sv
module cmosDatapath
  import cmosRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              addrSel,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] regC,
  output logic [DATA_W-1:0] regD
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] csumIn [CSUM_FIRST:CSUM_LAST];
  logic [CSUM_W-1:0] csumAcc;
  logic              csumHit;

  function automatic logic [DATA_W-1:0] rstByte(input int i);
    case (i)
      REG_A:   return RST_A;
      REG_B:   return RST_B;
      REG_C:   return RST_C;
      REG_D:   return RST_D;
      default: return '0;
    endcase
  endfunction

  // sum of the range as it will be after this cycle's write
  for (genvar g = CSUM_FIRST; g <= CSUM_LAST; g++) begin : gCsum
    assign csumIn[g] = (strb.wrPlain && strb.idx == IDX_W'(g)) ? wrData : mem[g];
  end

  always_comb begin
    csumAcc = '0;
    for (int i = CSUM_FIRST; i <= CSUM_LAST; i++) csumAcc = csumAcc + CSUM_W'(csumIn[i]);
  end

  assign csumHit = strb.wrPlain && (strb.idx >= IDX_W'(CSUM_FIRST))
                                && (strb.idx <= IDX_W'(CSUM_LAST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= rstByte(i);
    end else begin
      if (strb.wrPlain) mem[strb.idx] <= wrData;
      if (csumHit) begin
        mem[CSUM_HI] <= csumAcc[CSUM_W-1:DATA_W];
        mem[CSUM_LO] <= csumAcc[DATA_W-1:0];
      end
      if (strb.wrRegA) mem[REG_A][UIP_BIT-1:0] <= wrData[UIP_BIT-1:0];
      if (strb.wrRegB && wrData[SET_BIT]) mem[REG_A][UIP_BIT] <= 1'b0;
      else if (strb.uipClr)               mem[REG_A][UIP_BIT] <= 1'b0;
      else if (strb.uipSet)               mem[REG_A][UIP_BIT] <= 1'b1;
      if (strb.wrRegB) mem[REG_B] <= wrData;
      mem[REG_C] <= (strb.rdClrC ? '0 : mem[REG_C]) | strb.cSet;
    end
  end

  assign rdData = addrSel ? mem[strb.idx] : '1;
  assign regA   = mem[REG_A];
  assign regB   = mem[REG_B];
  assign regC   = mem[REG_C];
  assign regD   = mem[REG_D];
endmodule

// File: rtl/cmosRegPort.sv
module cmosRegPort
  import cmosRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic              evtPeriodic,
  input  logic              evtAlarm,
  input  logic              evtUpdate,
  input  logic              uipSet,
  input  logic              uipClr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              setMode
);
  ctlStrobes_t       strb;
  logic [DATA_W-1:0] regA, regB, regC, regD;

  cmosCtrl ctrlI (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe), .idxIn(wrData[IDX_W-1:0]),
    .evtPeriodic(evtPeriodic), .evtAlarm(evtAlarm), .evtUpdate(evtUpdate),
    .uipSet(uipSet), .uipClr(uipClr),
    .evtEn(regB[EN_LSB +: EVT_N]), .setModeIn(regB[SET_BIT]),
    .strb(strb), .irq(irq)
  );

  cmosDatapath dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .addrSel(addrSel),
    .rdData(rdData), .regA(regA), .regB(regB), .regC(regC), .regD(regD)
  );

  assign setMode = regB[SET_BIT];
endmodule

// File: rtl/cmosRegPortChk.sv
module cmosRegPortChk
  import cmosRegPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              addrSel,
  input logic [DATA_W-1:0] wrData,
  input logic              wrStrobe,
  input logic              rdStrobe,
  input logic              evtPeriodic,
  input logic              evtAlarm,
  input logic              evtUpdate,
  input logic              uipSet,
  input logic              uipClr,
  input logic [DATA_W-1:0] rdData,
  input logic              irq,
  input logic              setMode,
  input logic [IDX_W-1:0]  idx,
  input logic [DATA_W-1:0] regA,
  input logic [DATA_W-1:0] regC,
  input logic [DATA_W-1:0] regD
);
  logic anyEvt;
  assign anyEvt = evtPeriodic || evtAlarm || evtUpdate;

  a_r1_even_read_ff: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !addrSel) |-> rdData == 8'hFF);

  a_r3_uip_kept: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && addrSel && idx == IDX_A && !uipSet && !uipClr)
    |=> regA[UIP_BIT] == $past(regA[UIP_BIT]));

  a_r4_d_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && addrSel && idx == IDX_D) |=> $stable(regD));

  a_r4_c_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && addrSel && idx == IDX_C && !anyEvt) |=> $stable(regC));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && addrSel && idx == IDX_C && !anyEvt) |=> (regC == 8'h00 && !irq));

  a_r6_set_clears_uip: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && addrSel && idx == IDX_B && wrData[SET_BIT]) |=> (!regA[UIP_BIT] && setMode));

  a_r9_irq_tracks_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq == regC[ANY_BIT]);

  a_r11_uip_refused: assert property (@(posedge clk) disable iff (!rstN)
    (setMode && !regA[UIP_BIT]) |=> !regA[UIP_BIT]);
endmodule

bind cmosRegPort cmosRegPortChk chkI (
  .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrData(wrData),
  .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .evtPeriodic(evtPeriodic),
  .evtAlarm(evtAlarm), .evtUpdate(evtUpdate), .uipSet(uipSet), .uipClr(uipClr),
  .rdData(rdData), .irq(irq), .setMode(setMode), .idx(strb.idx),
  .regA(regA), .regC(regC), .regD(regD)
);

// File: tb/cmosRegPort_tb_top.sv
module cmosRegPort_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrStrobe = 1'b0, rdStrobe = 1'b0;
  logic       evtPeriodic = 1'b0, evtAlarm = 1'b0, evtUpdate = 1'b0;
  logic       uipSet = 1'b0, uipClr = 1'b0;
  logic [7:0] rdData;
  logic       irq, setMode;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cmosRegPort dut_i (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrData(wrData),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .evtPeriodic(evtPeriodic),
    .evtAlarm(evtAlarm), .evtUpdate(evtUpdate), .uipSet(uipSet), .uipClr(uipClr),
    .rdData(rdData), .irq(irq), .setMode(setMode)
  );

  // vector: {op, data, expected}; op 0 = index write, 1 = data write, 2 = data read
  localparam int NV = 25;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h05, 8'h00}, {2'd1, 8'h3C, 8'h00}, {2'd2, 8'h00, 8'h3C},  // R2 plain byte
    {2'd0, 8'h8A, 8'h00}, {2'd2, 8'h00, 8'h26},                        // R1 bit 7 dropped, R7
    {2'd1, 8'hFF, 8'h00}, {2'd2, 8'h00, 8'h7F},                        // R3 bit 7 kept at 0
    {2'd0, 8'h0D, 8'h00}, {2'd1, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h80},  // R4 status D
    {2'd0, 8'h0C, 8'h00}, {2'd1, 8'hFF, 8'h00}, {2'd2, 8'h00, 8'h00},  // R4 status C
    {2'd0, 8'h10, 8'h00}, {2'd1, 8'h12, 8'h00},                        // R8 range bytes
    {2'd0, 8'h11, 8'h00}, {2'd1, 8'hF0, 8'h00},
    {2'd0, 8'h2D, 8'h00}, {2'd1, 8'h01, 8'h00},
    {2'd0, 8'h2E, 8'h00}, {2'd2, 8'h00, 8'h01},                        // R8 high byte of 0x0103
    {2'd0, 8'h2F, 8'h00}, {2'd2, 8'h00, 8'h03},                        // R8 low byte
    {2'd0, 8'h05, 8'h00}, {2'd2, 8'h00, 8'h3C}                         // R2 byte kept
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addrSel = a; wrData = d; wrStrobe = 1'b1;
    @(posedge clk); #1;
    wrStrobe = 1'b0;
  endtask

  task automatic busRd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addrSel = a; rdStrobe = 1'b1;
    #1 d = rdData;
    @(posedge clk); #1;
    rdStrobe = 1'b0;
  endtask

  // which = {periodic, alarm, update, uipSet, uipClr}
  task automatic pulse(input logic [4:0] which);
    @(negedge clk);
    {evtPeriodic, evtAlarm, evtUpdate, uipSet, uipClr} = which;
    @(posedge clk); #1;
    {evtPeriodic, evtAlarm, evtUpdate, uipSet, uipClr} = '0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // reset state
    check("R7 irq", {7'd0, irq}, 8'h00);
    check("R7 setMode", {7'd0, setMode}, 8'h00);
    busRd(1'b0, v); check("R1 even read", v, 8'hFF);
    busWr(1'b0, 8'd11); busRd(1'b1, v); check("R7 B", v, 8'h02);
    busWr(1'b0, 8'd12); busRd(1'b1, v); check("R7 C", v, 8'h00);
    busWr(1'b0, 8'd13); busRd(1'b1, v); check("R7 D", v, 8'h80);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: busWr(1'b0, VEC[i][15:8]);
        2'd1: busWr(1'b1, VEC[i][15:8]);
        default: begin
          busRd(1'b1, v);
          check($sformatf("R1/R2/R3/R4/R7/R8 vector %0d", i), v, VEC[i][7:0]);
        end
      endcase
    end

    // R9 enabled periodic event, then R5 clearing read
    busWr(1'b0, 8'd11); busWr(1'b1, 8'h42);
    pulse(5'b10000);
    check("R9 irq raised", {7'd0, irq}, 8'h01);
    busWr(1'b0, 8'd12); busRd(1'b1, v); check("R9 flags", v, 8'hC0);
    check("R5 irq dropped", {7'd0, irq}, 8'h00);
    busRd(1'b1, v); check("R5 cleared", v, 8'h00);

    // R9 disabled alarm has no effect
    pulse(5'b01000);
    check("R9 disabled irq", {7'd0, irq}, 8'h00);
    busRd(1'b1, v); check("R9 disabled flags", v, 8'h00);

    // R10 event coinciding with clearing read
    busWr(1'b0, 8'd11); busWr(1'b1, 8'h72);
    pulse(5'b00100);
    busWr(1'b0, 8'd12);
    @(negedge clk);
    addrSel = 1'b1; rdStrobe = 1'b1; evtAlarm = 1'b1;
    #1 v = rdData;
    @(posedge clk); #1;
    rdStrobe = 1'b0; evtAlarm = 1'b0;
    check("R10 old flags", v, 8'h90);
    check("R10 irq held", {7'd0, irq}, 8'h01);
    busRd(1'b1, v); check("R10 new flags", v, 8'hA0);
    check("R5 irq after read", {7'd0, irq}, 8'h00);

    // R11 / R3 / R6 update-in-progress handling
    busWr(1'b0, 8'd11); busWr(1'b1, 8'h02);
    pulse(5'b00010);
    busWr(1'b0, 8'd10); busRd(1'b1, v); check("R11 uip set", v, 8'hFF);
    busWr(1'b1, 8'h26); busRd(1'b1, v); check("R3 uip kept high", v, 8'hA6);
    busWr(1'b0, 8'd11); busWr(1'b1, 8'h82);
    check("R6 setMode", {7'd0, setMode}, 8'h01);
    busWr(1'b0, 8'd10); busRd(1'b1, v); check("R6 uip cleared", v, 8'h26);
    pulse(5'b00010);
    busRd(1'b1, v); check("R11 refused in set mode", v, 8'h26);
    busWr(1'b0, 8'd11); busWr(1'b1, 8'h02);
    check("R6 setMode low", {7'd0, setMode}, 8'h00);
    pulse(5'b00010);
    busWr(1'b0, 8'd10); busRd(1'b1, v); check("R11 uip set again", v, 8'hA6);
    pulse(5'b00001);
    busRd(1'b1, v); check("R11 uip cleared", v, 8'h26);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule